// File: doc/BRIEF.md
# Time Base and Decrementer Timer

This block keeps a 64-bit time base that counts up and a 32-bit decrementer that counts down. Both move once per cycle in which the tick enable is high, so the tick rate is set by a divider outside the block. Software reaches both counters through a small register port. Each half of the time base can be read and written on its own. The decrementer can be read and written as one word.

When the decrementer passes through zero, it wraps to all ones and sets a sticky interrupt request. The request stays high until the clear input is pulsed. A write that takes the decrementer from a non-negative value to a negative one also sets the request at once. A reinitialise input, pulsed when the tick rate changes, sets the decrementer back to all ones and drops any pending request.

A legacy mode input restricts the lower time-base word to the bits under mask 0x3FFFFF80. The mask applies to both reads and writes of that word.

Top module: `tbdec_timer`

## Requirements
- R1: On each tick, with no time-base write in that cycle, the 64-bit time base increments by one, and a carry from the lower word reaches the upper word.
- R2: Register address encodings are as follows. Address 0 is the lower time-base word, bits 31:0. Address 1 is the upper word, bits 63:32. Address 2 is the decrementer. A read of address 3 returns zero, and a write to address 3 changes no state.
- R3: A write to the upper word leaves the lower word unchanged. A write to the lower word leaves the upper word unchanged.
- R4: While the legacy mode input is high, the lower word is masked with 0x3FFFFF80 on both read and write.
- R5: On a tick where the decrementer holds 0, the decrementer becomes 0xFFFFFFFF and the interrupt request is set on the same clock edge.
- R6: After reset, and on the edge after a reinitialise pulse, the decrementer holds 0xFFFFFFFF and the interrupt request is low.
- R7: A decrementer write whose data has bit 31 set, while the current value has bit 31 clear, sets the interrupt request on the same edge. A write that does not make this sign change does not set the request.
- R8: Once set, the interrupt request stays high until the clear input is sampled high. If a set and a clear arrive in the same cycle, the set wins.
- R9: A register write in the same cycle as a tick loads the written value into that register in place of the increment or decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Advances both counters when high |
| reinit | input | 1 | Tick-rate change: decrementer to all ones, request dropped |
| legacy_mode | input | 1 | Masks the lower time-base word |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_clr | input | 1 | Clears the interrupt request |
| dec_irq | output | 1 | Sticky decrementer interrupt request |

## Verification
The hardest case to reach from the ports is a decrementer expiry. From reset, that would take four billion ticks. The stimulus avoids this by writing a small count, ticking it down to zero, and then giving one more tick.

The same shortcut sets up the sign-change case. The decrementer is written with a non-negative value just before the negative write. For the non-firing variant, the decrementer is first made negative, so the second negative write must not set the request.

Carry into the upper word is reached the same way, by writing 0xFFFFFFFF to the lower word before a single tick.

// File: rtl/tbdec_pkg.sv
package tbdec_pkg;
  typedef enum logic [1:0] {
    ADDR_TB_LO = 2'd0,
    ADDR_TB_HI = 2'd1,
    ADDR_DEC   = 2'd2,
    ADDR_NONE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tbdec_regif.sv
module tbdec_regif import tbdec_pkg::*; #(
  parameter int          DW       = 32,
  parameter logic [31:0] LEG_MASK = 32'h3FFF_FF80
) (
  input  logic [1:0]      reg_addr,
  input  logic            reg_we,
  input  logic [DW-1:0]   reg_wdata,
  input  logic            legacy_mode,
  input  logic [2*DW-1:0] tb_val,
  input  logic [DW-1:0]   dec_val,
  output logic            we_lo,
  output logic            we_hi,
  output logic            we_dec,
  output logic [DW-1:0]   wdata_o,
  output logic [DW-1:0]   rdata
);
  localparam logic [DW-1:0] MASK = DW'(LEG_MASK);

  reg_addr_e sel;
  assign sel = reg_addr_e'(reg_addr);

  always_comb begin
    we_lo   = reg_we && (sel == ADDR_TB_LO);
    we_hi   = reg_we && (sel == ADDR_TB_HI);
    we_dec  = reg_we && (sel == ADDR_DEC);
    wdata_o = reg_wdata;
    if (legacy_mode && sel == ADDR_TB_LO) wdata_o = reg_wdata & MASK;
  end

  always_comb begin
    unique case (sel)
      ADDR_TB_LO: rdata = legacy_mode ? (tb_val[DW-1:0] & MASK) : tb_val[DW-1:0];
      ADDR_TB_HI: rdata = tb_val[2*DW-1:DW];
      ADDR_DEC:   rdata = dec_val;
      default:    rdata = '0;
    endcase
  end

  // R4: legacy reads of the lower word never show bits outside the mask
  always_comb begin
    if (legacy_mode && sel == ADDR_TB_LO)
      assert_legacy_read_mask_R4: assert ((rdata & ~MASK) == '0);
  end
endmodule

// File: rtl/tbdec_timebase.sv
module tbdec_timebase #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            we_lo,
  input  logic            we_hi,
  input  logic [DW-1:0]   wdata,
  output logic [2*DW-1:0] tb_q
);
  localparam int TBW = 2 * DW;

  logic [TBW-1:0] tb_d;
  logic           tb_en;

  always_comb begin
    tb_en = we_lo || we_hi || tick;
    tb_d  = tb_q;
    if (we_lo)      tb_d = {tb_q[TBW-1:DW], wdata};
    else if (we_hi) tb_d = {wdata, tb_q[DW-1:0]};
    else if (tick)  tb_d = tb_q + TBW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tb_q <= '0;
    else if (tb_en) tb_q <= tb_d;
  end

  assert_tb_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !we_lo && !we_hi) |=> (tb_q == $past(tb_q) + TBW'(1)));
  assert_lo_write_keeps_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we_lo |=> (tb_q[TBW-1:DW] == $past(tb_q[TBW-1:DW])));
  assert_hi_write_keeps_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_hi && !we_lo) |=> (tb_q[DW-1:0] == $past(tb_q[DW-1:0])));
  assert_write_beats_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we_lo && tick) |=> (tb_q[DW-1:0] == $past(wdata)));
endmodule

// File: rtl/tbdec_decrementer.sv
module tbdec_decrementer #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          reinit,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          irq_clr,
  output logic [DW-1:0] dec_q,
  output logic          irq_q
);
  localparam logic [DW-1:0] ALL_ONES = '1;
  localparam int            MSB      = DW - 1;

  logic [DW-1:0] dec_d;
  logic          irq_d;
  logic          expire;
  logic          sign_flip;

  always_comb begin
    expire    = tick && !we && (dec_q == '0);
    sign_flip = we && wdata[MSB] && !dec_q[MSB];
    dec_d     = dec_q;
    irq_d     = irq_q;
    if (reinit) begin
      dec_d = ALL_ONES;
      irq_d = 1'b0;
    end else begin
      if (we)        dec_d = wdata;
      else if (tick) dec_d = dec_q - DW'(1);
      if (expire || sign_flip) irq_d = 1'b1;
      else if (irq_clr)        irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q <= ALL_ONES;
      irq_q <= 1'b0;
    end else begin
      dec_q <= dec_d;
      irq_q <= irq_d;
    end
  end

  assert_expiry_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !we && !reinit && dec_q == '0) |=> (dec_q == ALL_ONES && irq_q));
  assert_reinit_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> (dec_q == ALL_ONES && !irq_q));
  assert_sign_flip_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !reinit && wdata[MSB] && !dec_q[MSB]) |=> irq_q);
  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr && !reinit) |=> irq_q);
  assert_dec_write_beats_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && tick && !reinit) |=> (dec_q == $past(wdata)));
endmodule

// File: rtl/tbdec_timer.sv
module tbdec_timer import tbdec_pkg::*; #(
  parameter int          DW       = 32,
  parameter logic [31:0] LEG_MASK = 32'h3FFF_FF80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          reinit,
  input  logic          legacy_mode,
  input  logic [1:0]    reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          irq_clr,
  output logic          dec_irq
);
  localparam int TBW = 2 * DW;

  // reset asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic           we_lo, we_hi, we_dec;
  logic [DW-1:0]  wdata_m;
  logic [TBW-1:0] tb_val;
  logic [DW-1:0]  dec_val;

  tbdec_regif #(.DW(DW), .LEG_MASK(LEG_MASK)) u_regif (
    .reg_addr    (reg_addr),
    .reg_we      (reg_we),
    .reg_wdata   (reg_wdata),
    .legacy_mode (legacy_mode),
    .tb_val      (tb_val),
    .dec_val     (dec_val),
    .we_lo       (we_lo),
    .we_hi       (we_hi),
    .we_dec      (we_dec),
    .wdata_o     (wdata_m),
    .rdata       (reg_rdata)
  );

  tbdec_timebase #(.DW(DW)) u_tb (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (tick_en),
    .we_lo (we_lo),
    .we_hi (we_hi),
    .wdata (wdata_m),
    .tb_q  (tb_val)
  );

  tbdec_decrementer #(.DW(DW)) u_dec (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (tick_en),
    .reinit  (reinit),
    .we      (we_dec),
    .wdata   (wdata_m),
    .irq_clr (irq_clr),
    .dec_q   (dec_val),
    .irq_q   (dec_irq)
  );

  assert_unmapped_write_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_we && reg_addr == 2'd3 && !tick_en && !reinit) |=>
      (tb_val == $past(tb_val) && dec_val == $past(dec_val)));
endmodule

// File: tb/tbdec_timer_tb.sv
module tbdec_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        reinit = 1'b0;
  logic        legacy_mode = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_clr = 1'b0;
  logic        dec_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tbdec_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reinit(reinit),
    .legacy_mode(legacy_mode), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_clr(irq_clr),
    .dec_irq(dec_irq)
  );

  // vector: {addr[1:0], legacy, wdata[31:0], expected readback[31:0]}
  localparam int NV = 5;
  localparam logic [66:0] VEC [NV] = '{
    {2'd0, 1'b0, 32'h1234_5678, 32'h1234_5678},
    {2'd1, 1'b0, 32'hCAFE_F00D, 32'hCAFE_F00D},
    {2'd0, 1'b1, 32'hFFFF_FFFF, 32'h3FFF_FF80},
    {2'd2, 1'b0, 32'h0000_0010, 32'h0000_0010},
    {2'd3, 1'b0, 32'h0000_DEAD, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic tk);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1; tick_en = tk;
    @(negedge clk);
    reg_we = 1'b0; tick_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd(2'd0, v); check("R6 reset tb_lo", v, 32'h0);
    rd(2'd1, v); check("R6 reset tb_hi", v, 32'h0);
    rd(2'd2, v); check("R6 reset dec", v, 32'hFFFF_FFFF);
    check("R6 reset irq", {31'b0, dec_irq}, 32'h0);

    // table walk: write then read back (R2, R4)
    for (int i = 0; i < NV; i++) begin
      legacy_mode = VEC[i][64];
      wr(VEC[i][66:65], VEC[i][63:32], 1'b0);
      rd(VEC[i][66:65], v);
      check($sformatf("R2/R4 vector %0d", i), v, VEC[i][31:0]);
    end
    legacy_mode = 1'b0;
    rd(2'd2, v); check("R2 unmapped write leaves dec", v, 32'h10);

    // R3: upper write keeps lower
    wr(2'd0, 32'h0000_0055, 1'b0);
    wr(2'd1, 32'h0000_0077, 1'b0);
    rd(2'd0, v); check("R3 lo kept", v, 32'h55);
    wr(2'd0, 32'h0000_0099, 1'b0);
    rd(2'd1, v); check("R3 hi kept", v, 32'h77);

    // R1: carry into upper word
    wr(2'd0, 32'hFFFF_FFFF, 1'b0);
    wr(2'd1, 32'h0000_0001, 1'b0);
    ticks(1);
    rd(2'd0, v); check("R1 lo wrap", v, 32'h0);
    rd(2'd1, v); check("R1 carry", v, 32'h2);

    // R4: legacy read mask on stored full word
    wr(2'd0, 32'hFFFF_FFFF, 1'b0);
    legacy_mode = 1'b1;
    rd(2'd0, v); check("R4 read mask", v, 32'h3FFF_FF80);
    legacy_mode = 1'b0;

    // R5: countdown and expiry
    wr(2'd2, 32'h3, 1'b0);
    ticks(3);
    rd(2'd2, v); check("R5 at zero", v, 32'h0);
    check("R5 no irq yet", {31'b0, dec_irq}, 32'h0);
    ticks(1);
    rd(2'd2, v); check("R5 wrap", v, 32'hFFFF_FFFF);
    check("R5 irq set", {31'b0, dec_irq}, 32'h1);

    // R8: sticky until clear
    repeat (5) @(negedge clk);
    check("R8 irq held", {31'b0, dec_irq}, 32'h1);
    pulse_clr();
    check("R8 irq cleared", {31'b0, dec_irq}, 32'h0);

    // R7: sign change from non-negative
    wr(2'd2, 32'h5, 1'b0);
    check("R7 no irq on positive", {31'b0, dec_irq}, 32'h0);
    wr(2'd2, 32'h8000_0000, 1'b0);
    check("R7 irq on sign flip", {31'b0, dec_irq}, 32'h1);
    pulse_clr();
    wr(2'd2, 32'h8000_0001, 1'b0);
    check("R7 no irq negative to negative", {31'b0, dec_irq}, 32'h0);

    // R9: write beats tick
    wr(2'd0, 32'h0000_0100, 1'b1);
    rd(2'd0, v); check("R9 tb write with tick", v, 32'h100);
    wr(2'd2, 32'h0000_0040, 1'b1);
    rd(2'd2, v); check("R9 dec write with tick", v, 32'h40);

    // R6: reinit drops pending request
    wr(2'd2, 32'h0, 1'b0);
    ticks(1);
    check("R6 irq before reinit", {31'b0, dec_irq}, 32'h1);
    @(negedge clk); reinit = 1'b1;
    @(negedge clk); reinit = 1'b0;
    rd(2'd2, v); check("R6 reinit dec", v, 32'hFFFF_FFFF);
    check("R6 reinit irq", {31'b0, dec_irq}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule